// File: doc/BRIEF.md
# BCD Calendar Clock with Frozen User Registers

This block keeps calendar time (seconds, minutes, hours, day of week, date, month and a four-digit year) in packed BCD. It advances by one second for every pulse on its tick input. A processor reaches it through a small synchronous register bus made of an address, a write strobe, write data and combinational read data.

Two copies of the time are held. The live counters always run. A second, user-visible copy is what the bus reads and writes. A flags register carries two hold bits:

- **Read-hold** freezes the visible copy so that software can read a consistent snapshot while the live counters keep counting.
- **Write-hold** turns the visible copy into a scratch area where software composes a base time. Clearing write-hold copies that base time into the live counters in one cycle.

Top module: `rtc_calendar_regs`

## Requirements
- R1: After reset the visible time is 00:00:00, day of week 1, date 01, month 01, year 0000, and both hold bits read 0.
- R2: Each cycle with `tick_i` high advances the live time by one second. Seconds 59 wraps to 00 and carries into minutes. Minutes 59 wraps to 00 and carries into hours. Hours 23 wraps to 00 and carries into the date.
- R3: Day of week counts 1 to 7 and steps from 7 back to 1 at midnight.
- R4: The last date of each month is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for 04, 06, 09 and 11. February ends on 29 when the year is a leap year and on 28 otherwise. A year is a leap year when it is divisible by 4 and not by 100, or when it is divisible by 400. After the last date the date returns to 01, and month 12 steps to 01 with the year incremented.
- R5: The year is four BCD digits. Address 6 holds the low two digits and address 7 holds the high two digits. Year 9999 steps to 0000.
- R6: Register map, with all values in BCD and hours in 24-hour form. Address 0 is seconds in bits 6:0. Address 1 is minutes in bits 6:0. Address 2 is hours in bits 5:0. Address 3 is day of week in bits 2:0. Address 4 is date in bits 5:0. Address 5 is month in bits 4:0. Address 8 is flags: bit 0 is read-hold and bit 1 is write-hold. Bits outside each field always read 0, and write data in them is dropped. Read data is combinational from the address.
- R7: While both hold bits are 0, the visible registers equal the live time after every processed tick, updated on the same edge.
- R8: While read-hold is 1, the visible registers do not change even though ticks advance the live time. After read-hold is cleared, the next tick refreshes all visible registers at once to the current live time.
- R9: A write to addresses 0 to 7 while write-hold is 0 has no effect.
- R10: While write-hold is 1, writes to addresses 0 to 7 land in the visible registers, masked to the field width, and ticks do not refresh them.
- R11: The flags write that clears write-hold loads the visible registers into the live counters on that edge. A tick in the same cycle is dropped, and counting resumes from the base time on the next tick.
- R12: Addresses 9 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second advance pulse, one cycle wide |
| bus_addr_i | input | ADDR_W (4) | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |

## Verification
The assertions check the following on every cycle:
- The live counters stay still without a tick and always move on a processed tick.
- A commit loads exactly the visible copy into the live counters.
- An unheld refresh leaves the visible copy equal to the live counters.
- A held read snapshot never changes.
- Ignored time writes and unmapped addresses leave no trace.

Whether the calendar arithmetic is right can only be shown by the bench's scenarios. These cover month lengths across leap, century and 400-year cases, the 9999 wrap, a full day of ticks, and the order of events around hold release, including a tick that collides with the commit.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

  localparam int unsigned NUM_TIME_REGS = 8;
  localparam int unsigned IDX_W         = $clog2(NUM_TIME_REGS);

  typedef struct packed {
    logic [15:0] year;
    logic [4:0]  month;
    logic [5:0]  date;
    logic [2:0]  dow;
    logic [5:0]  hour;
    logic [6:0]  min;
    logic [6:0]  sec;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET = '{year: 16'h0000, month: 5'h01, date: 6'h01,
                                      dow: 3'd1, hour: 6'h00, min: 7'h00, sec: 7'h00};

  // Two-digit BCD increment without wrap handling.
  function automatic logic [7:0] bcd_inc2(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic int unsigned bcd_val(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic is_leap(input logic [15:0] y);
    int unsigned lo;
    int unsigned hi;
    lo = bcd_val(y[7:0]);
    hi = bcd_val(y[15:8]);
    if (lo != 0) return (lo % 4) == 0;
    return (hi % 4) == 0;
  endfunction

  function automatic logic [5:0] month_last(input logic [4:0] m, input logic [15:0] y);
    case (m)
      5'h02:                      return is_leap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  function automatic logic [15:0] year_inc(input logic [15:0] y);
    if (y == 16'h9999)     return 16'h0000;
    if (y[7:0] == 8'h99)   return {bcd_inc2(y[15:8]), 8'h00};
    return {y[15:8], bcd_inc2(y[7:0])};
  endfunction

  // Full one-second calendar step.
  function automatic rtc_time_t rtc_advance(input rtc_time_t t);
    rtc_time_t  n;
    logic [7:0] tmp;
    n = t;
    if (t.sec != 7'h59) begin
      tmp = bcd_inc2({1'b0, t.sec});
      n.sec = tmp[6:0];
      return n;
    end
    n.sec = 7'h00;
    if (t.min != 7'h59) begin
      tmp = bcd_inc2({1'b0, t.min});
      n.min = tmp[6:0];
      return n;
    end
    n.min = 7'h00;
    if (t.hour != 6'h23) begin
      tmp = bcd_inc2({2'b0, t.hour});
      n.hour = tmp[5:0];
      return n;
    end
    n.hour = 6'h00;
    n.dow  = (t.dow == 3'd7) ? 3'd1 : t.dow + 3'd1;
    if (t.date != month_last(t.month, t.year)) begin
      tmp = bcd_inc2({2'b0, t.date});
      n.date = tmp[5:0];
      return n;
    end
    n.date = 6'h01;
    if (t.month != 5'h12) begin
      tmp = bcd_inc2({3'b0, t.month});
      n.month = tmp[4:0];
      return n;
    end
    n.month = 5'h01;
    n.year  = year_inc(t.year);
    return n;
  endfunction

  function automatic logic [7:0] get_field(input rtc_time_t t, input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    return {1'b0, t.sec};
      3'd1:    return {1'b0, t.min};
      3'd2:    return {2'b0, t.hour};
      3'd3:    return {5'b0, t.dow};
      3'd4:    return {2'b0, t.date};
      3'd5:    return {3'b0, t.month};
      3'd6:    return t.year[7:0];
      default: return t.year[15:8];
    endcase
  endfunction

  function automatic rtc_time_t put_field(input rtc_time_t t, input logic [IDX_W-1:0] idx,
                                          input logic [7:0] d);
    rtc_time_t n;
    n = t;
    case (idx)
      3'd0:    n.sec        = d[6:0];
      3'd1:    n.min        = d[6:0];
      3'd2:    n.hour       = d[5:0];
      3'd3:    n.dow        = d[2:0];
      3'd4:    n.date       = d[5:0];
      3'd5:    n.month      = d[4:0];
      3'd6:    n.year[7:0]  = d;
      default: n.year[15:8] = d;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/rtc_time_counter.sv
`timescale 1ns/1ps
module rtc_time_counter
  import rtc_cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_i,
  input  logic      load_i,
  input  rtc_time_t base_i,
  output rtc_time_t live_q,
  output rtc_time_t live_nxt,
  output logic      tick_taken
);

  rtc_time_t stepped;

  assign stepped    = rtc_advance(live_q);
  assign tick_taken = tick_i && !load_i;
  assign live_nxt   = load_i ? base_i : (tick_i ? stepped : live_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= RTC_RESET;
    else        live_q <= live_nxt;
  end

  // R2: no tick, no load -> live time holds
  a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(live_q));

  // R2: a processed tick always moves the live time
  a_r2_tick_moves: assert property (@(posedge clk) disable iff (!rst_n)
    tick_taken |=> (live_q != $past(live_q)));

  // R11: load wins over tick
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (live_q == $past(base_i)));

endmodule

// File: rtl/rtc_user_regs.sv
`timescale 1ns/1ps
module rtc_user_regs
  import rtc_cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_hold,
  input  logic             wr_hold,
  input  logic             tick_taken,
  input  rtc_time_t        live_nxt,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  output rtc_time_t        shadow_q,
  output logic             refresh,
  output logic             base_wr
);

  assign refresh = tick_taken && !rd_hold && !wr_hold;
  assign base_wr = wr_en && wr_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shadow_q <= RTC_RESET;
    else if (base_wr) shadow_q <= put_field(shadow_q, wr_idx, wr_data);
    else if (refresh) shadow_q <= live_nxt;
  end

  // R8: a read snapshot is frozen while only read-hold is set
  a_r8_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hold && !wr_hold) |=> $stable(shadow_q));

endmodule

// File: rtl/rtc_calendar_regs.sv
`timescale 1ns/1ps
module rtc_calendar_regs
  import rtc_cal_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned FLAG_ADDR = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o
);

  localparam logic [ADDR_W-1:0] FLAG_SEL = ADDR_W'(FLAG_ADDR);
  localparam logic [ADDR_W-1:0] TIME_END = ADDR_W'(NUM_TIME_REGS);

  logic      rd_hold_q, wr_hold_q;
  logic      time_sel, flag_sel, time_wr, flag_wr, commit;
  logic      tick_taken, refresh, base_wr;
  rtc_time_t live_q, live_nxt, shadow_q;

  assign time_sel = bus_addr_i < TIME_END;
  assign flag_sel = bus_addr_i == FLAG_SEL;
  assign time_wr  = bus_we_i && time_sel;
  assign flag_wr  = bus_we_i && flag_sel;
  assign commit   = flag_wr && wr_hold_q && !bus_wdata_i[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hold_q <= 1'b0;
      wr_hold_q <= 1'b0;
    end else if (flag_wr) begin
      rd_hold_q <= bus_wdata_i[0];
      wr_hold_q <= bus_wdata_i[1];
    end
  end

  rtc_time_counter u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .load_i     (commit),
    .base_i     (shadow_q),
    .live_q     (live_q),
    .live_nxt   (live_nxt),
    .tick_taken (tick_taken)
  );

  rtc_user_regs u_user (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_hold    (rd_hold_q),
    .wr_hold    (wr_hold_q),
    .tick_taken (tick_taken),
    .live_nxt   (live_nxt),
    .wr_en      (time_wr),
    .wr_idx     (bus_addr_i[IDX_W-1:0]),
    .wr_data    (bus_wdata_i),
    .shadow_q   (shadow_q),
    .refresh    (refresh),
    .base_wr    (base_wr)
  );

  always_comb begin
    if (time_sel)      bus_rdata_o = get_field(shadow_q, bus_addr_i[IDX_W-1:0]);
    else if (flag_sel) bus_rdata_o = {6'b0, wr_hold_q, rd_hold_q};
    else               bus_rdata_o = 8'h00;
  end

  // R7: unheld refresh mirrors the live counters
  a_r7_mirror_live: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (shadow_q == live_q));

  // R11: commit copies the composed base into the counters
  a_r11_commit_base: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (live_q == $past(shadow_q)));

  // R9: time writes without write-hold leave the visible copy alone
  a_r9_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (time_wr && !wr_hold_q && !tick_i) |=> $stable(shadow_q));

  // R12: addresses past the flags read zero
  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i > FLAG_SEL) |-> (bus_rdata_o == 8'h00));

  // R6: day-of-week register keeps its upper bits clear
  a_r6_dow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == ADDR_W'(3)) |-> (bus_rdata_o[7:3] == 5'b0));

endmodule

// File: tb/rtc_calendar_regs_test.sv
`timescale 1ns/1ps
module rtc_calendar_regs_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int n_run = 0;
  int n_bad = 0;
  bit done  = 0;

  int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr;
  logic [7:0] snap [8];

  rtc_calendar_regs uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic bit leap(input int y);
    return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return leap(y) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_reg(input int i);
    case (i)
      0: return to_bcd(m_sec);
      1: return to_bcd(m_min);
      2: return to_bcd(m_hr);
      3: return to_bcd(m_dow);
      4: return to_bcd(m_date);
      5: return to_bcd(m_mon);
      6: return to_bcd(m_yr % 100);
      default: return to_bcd(m_yr / 100);
    endcase
  endfunction

  task automatic model_step();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0;
          m_dow = m_dow % 7 + 1;
          m_date++;
          if (m_date > dim(m_mon, m_yr)) begin
            m_date = 1; m_mon++;
            if (m_mon > 12) begin
              m_mon = 1;
              m_yr = (m_yr + 1) % 10000;
            end
          end
        end
      end
    end
  endtask

  task automatic check(input string req, input string what, input logic [7:0] got,
                       input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    addr = 4'(a);
    #1;
    v = rdata;
  endtask

  task automatic check_regs(input string req);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(i, v);
      check(req, $sformatf("reg%0d", i), v, exp_reg(i));
    end
  endtask

  task automatic check_snap(input string req);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(i, v);
      check(req, $sformatf("frozen reg%0d", i), v, snap[i]);
    end
  endtask

  task automatic bus_write(input int a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = 4'(a); wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(posedge clk);
    #1 tick = 1'b0;
    model_step();
  endtask

  task automatic set_base(input int h, input int mi, input int s, input int dw,
                          input int dt, input int mo, input int y);
    bus_write(8, 8'h02);
    bus_write(0, to_bcd(s));
    bus_write(1, to_bcd(mi));
    bus_write(2, to_bcd(h));
    bus_write(3, to_bcd(dw));
    bus_write(4, to_bcd(dt));
    bus_write(5, to_bcd(mo));
    bus_write(6, to_bcd(y % 100));
    bus_write(7, to_bcd(y / 100));
    bus_write(8, 8'h00);
    m_sec = s; m_min = mi; m_hr = h; m_dow = dw; m_date = dt; m_mon = mo; m_yr = y;
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int years [6] = '{2023, 2024, 1900, 2000, 2100, 9999};
    m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset contents and flags
    check_regs("R1");
    rd(8, v); check("R1", "flags", v, 8'h00);
    // R12: unmapped addresses
    for (int a = 9; a < 16; a++) begin
      rd(a, v); check("R12", $sformatf("addr%0d", a), v, 8'h00);
    end

    // R4 / R5: month ends over leap, century and 400-year cases
    foreach (years[k]) begin
      for (int m = 1; m <= 12; m++) begin
        set_base(23, 59, 59, m % 7 + 1, dim(m, years[k]), m, years[k]);
        pulse_tick();
        check_regs((m == 12) ? "R5" : "R4");
      end
      set_base(23, 59, 59, 2, 28, 2, years[k]);
      pulse_tick();
      check_regs("R4");
    end

    // R3: day of week wrap
    set_base(23, 59, 59, 7, 10, 3, 2024);
    pulse_tick();
    rd(3, v); check("R3", "dow wrap", v, 8'h01);

    // R2 / R7: full day of ticks across a year end
    set_base(0, 0, 0, 6, 31, 12, 1999);
    for (int t = 1; t <= 86400; t++) begin
      pulse_tick();
      if (t % 3600 == 0) check_regs("R7");
    end
    check_regs("R2");

    // R9: write with no hold is dropped
    bus_write(0, to_bcd((m_sec + 17) % 60));
    rd(0, v); check("R9", "sec after unheld write", v, exp_reg(0));

    // R8: read-hold snapshot
    bus_write(8, 8'h01);
    rd(8, v); check("R6", "flags read-hold", v, 8'h01);
    for (int i = 0; i < 8; i++) snap[i] = exp_reg(i);
    repeat (5) pulse_tick();
    check_snap("R8");
    bus_write(1, to_bcd((m_min + 23) % 60));
    rd(1, v); check("R9", "min under read-hold", v, snap[1]);
    bus_write(8, 8'h00);
    check_snap("R8");
    pulse_tick();
    check_regs("R8");

    // R10 / R6: composing a base time under write-hold
    bus_write(8, 8'h02);
    rd(8, v); check("R6", "flags write-hold", v, 8'h02);
    bus_write(0, 8'hC5);
    rd(0, v); check("R6", "sec masked", v, 8'h45);
    bus_write(3, 8'hFF);
    rd(3, v); check("R6", "dow masked", v, 8'h07);
    repeat (2) pulse_tick();
    rd(0, v); check("R10", "sec held over ticks", v, 8'h45);
    bus_write(1, 8'h20);
    bus_write(2, 8'h10);
    bus_write(4, 8'h15);
    bus_write(5, 8'h06);
    bus_write(6, 8'h77);
    bus_write(7, 8'h20);

    // R11: release write-hold together with a tick
    @(negedge clk);
    we = 1'b1; addr = 4'd8; wdata = 8'h00; tick = 1'b1;
    @(posedge clk);
    #1 we = 1'b0; tick = 1'b0;
    m_sec = 45; m_min = 20; m_hr = 10; m_dow = 7; m_date = 15; m_mon = 6; m_yr = 2077;
    rd(8, v); check("R11", "flags after release", v, 8'h00);
    check_regs("R11");
    pulse_tick();
    check_regs("R11");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule